// File: doc/BRIEF.md
# Shift, Rotate and Status-Flag Unit

This block is the one-cycle bit datapath of a small 8-bit processor core, and it owns the core's 8-bit status word. Each cycle the decoder gives it an operation code, one register operand, a bit index and a flag index. It returns a result byte, a strobe that tells the register file to write that byte back, and the next status word. The status word is committed on the same clock edge.

It covers shifts, rotates, arithmetic shift right and nibble exchange. It copies single bits between a register and the transfer flag (T), and it forces any one status flag to 1 or to 0. Rotates take their fill bit from the carry flag and return the bit they shift out to carry. Each operation touches only its own set of flags. All other flags hold their value.

Status bits, from bit 7 down to bit 0: I (interrupt enable), T (transfer), H (half carry), S (sign test), V (overflow), N (negative), Z (zero), C (carry).

Top module: `bitops_unit`

## Requirements
- R1: A clock edge with `rst` high loads the status word with 0x00, whatever operation is presented in that cycle.
- R2: Operation code 1 (shift left) gives result = operand shifted up one place with bit 0 = 0. The new C is operand bit 7.
- R3: Operation code 2 (logical shift right) gives result = operand shifted down one place with bit 7 = 0. The new C is operand bit 0.
- R4: Operation code 3 (rotate left via carry) gives result = operand shifted up one place with bit 0 = old C. The new C is operand bit 7.
- R5: Operation code 4 (rotate right via carry) gives result = operand shifted down one place with bit 7 = old C. The new C is operand bit 0.
- R6: Operation code 5 (arithmetic shift right) gives result bits 6..0 = operand bits 7..1, and bit 7 keeps operand bit 7. The new C is operand bit 0.
- R7: For codes 1 to 5, result write is asserted and the flags update as follows: Z (bit 1) = result is zero, N (bit 2) = result bit 7, V (bit 3) = N xor C, S (bit 4) = N xor V. I, T and H (bits 7, 6, 5) keep their values.
- R8: Operation code 6 (nibble exchange) gives result bits 7..4 = operand bits 3..0 and result bits 3..0 = operand bits 7..4. Result write is asserted and the status word is unchanged.
- R9: Operation code 7 (bit to T) copies operand bit `bit_idx` into T (status bit 6). All other status bits are unchanged and result write is low.
- R10: Operation code 8 (T to bit) gives result = operand with bit `bit_idx` replaced by T. Result write is asserted and the status word is unchanged.
- R11: Operation code 9 sets and code 10 clears the status bit at position `flag_idx` (7 = I ... 0 = C). All other bits are unchanged and result write is low.
- R12: Operation code 0 and codes 11 to 15 leave the status word unchanged and keep result write low.
- R13: `sreg_next` shows the updated status word in the same cycle the operation is presented. `sreg` takes that value on the next clock edge, so every operation completes in one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the status word |
| op_sel | input | 4 | Operation code (see requirements) |
| operand | input | 8 | Register operand |
| bit_idx | input | 3 | Register bit position for codes 7 and 8 |
| flag_idx | input | 3 | Status bit position for codes 9 and 10 |
| result | output | 8 | Result byte, valid when `result_we` is high |
| result_we | output | 1 | Write-back strobe for `result` |
| sreg_next | output | 8 | Status word to be committed at the next edge |
| sreg | output | 8 | Current status word |

## Verification
The properties assume that `op_sel`, `operand`, `bit_idx` and `flag_idx` are known (not X) at every sampling edge outside reset. They also assume that every input is stable from one edge to the next. The bench meets this by changing inputs only on the falling edge and by driving every input on every operation, with unused indices set to zero. Codes 11 to 15 are legal input and must act as no-ops, so the bench includes an undefined code on purpose. The bench builds each starting status word only from set-flag and clear-flag operations. Any status pattern can be reached this way without probing internal state.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

    localparam int unsigned WORD_W = 8;
    localparam int unsigned STAT_W = 8;
    localparam int unsigned OP_W   = 4;

    // status bit positions
    localparam int unsigned FLG_C = 0;
    localparam int unsigned FLG_Z = 1;
    localparam int unsigned FLG_N = 2;
    localparam int unsigned FLG_V = 3;
    localparam int unsigned FLG_S = 4;
    localparam int unsigned FLG_H = 5;
    localparam int unsigned FLG_T = 6;
    localparam int unsigned FLG_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_SHL  = 4'd1,
        OP_SHR  = 4'd2,
        OP_RCL  = 4'd3,
        OP_RCR  = 4'd4,
        OP_SAR  = 4'd5,
        OP_NSWP = 4'd6,
        OP_TSTO = 4'd7,
        OP_TLOD = 4'd8,
        OP_FSET = 4'd9,
        OP_FCLR = 4'd10
    } bop_e;

    typedef enum logic [2:0] {
        SRC_PASS,
        SRC_SHIFT,
        SRC_SWAP,
        SRC_INSERT
    } res_src_e;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_ARITH,
        ST_TCOPY,
        ST_FORCE
    } stat_src_e;

    typedef struct packed {
        res_src_e  res_src;
        stat_src_e stat_src;
        logic      wr_result;
        logic      force_val;
    } bop_ctrl_t;

    function automatic bop_ctrl_t decode_op(input logic [OP_W-1:0] code);
        bop_ctrl_t c;
        c.res_src   = SRC_PASS;
        c.stat_src  = ST_HOLD;
        c.wr_result = 1'b0;
        c.force_val = 1'b0;
        case (code)
            OP_SHL, OP_SHR, OP_RCL, OP_RCR, OP_SAR: begin
                c.res_src   = SRC_SHIFT;
                c.stat_src  = ST_ARITH;
                c.wr_result = 1'b1;
            end
            OP_NSWP: begin
                c.res_src   = SRC_SWAP;
                c.wr_result = 1'b1;
            end
            OP_TSTO: c.stat_src = ST_TCOPY;
            OP_TLOD: begin
                c.res_src   = SRC_INSERT;
                c.wr_result = 1'b1;
            end
            OP_FSET: begin
                c.stat_src  = ST_FORCE;
                c.force_val = 1'b1;
            end
            OP_FCLR: c.stat_src = ST_FORCE;
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic is_shift_op(input logic [OP_W-1:0] code);
        return (code >= OP_SHL) && (code <= OP_SAR);
    endfunction

endpackage

// File: rtl/bitops_shifter.sv
module bitops_shifter
    import bitops_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [OP_W-1:0] op_code,
    input  logic [W-1:0]    din,
    input  logic            cin,
    output logic [W-1:0]    dout,
    output logic            cout
);

    always_comb begin
        dout = din;
        cout = cin;
        case (op_code)
            OP_SHL: begin
                dout = {din[W-2:0], 1'b0};
                cout = din[W-1];
            end
            OP_SHR: begin
                dout = {1'b0, din[W-1:1]};
                cout = din[0];
            end
            OP_RCL: begin
                dout = {din[W-2:0], cin};
                cout = din[W-1];
            end
            OP_RCR: begin
                dout = {cin, din[W-1:1]};
                cout = din[0];
            end
            OP_SAR: begin
                dout = {din[W-1], din[W-1:1]};
                cout = din[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bitops_flagcalc.sv
module bitops_flagcalc
    import bitops_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int SW = STAT_W
) (
    input  logic [W-1:0]  value,
    input  logic          carry,
    input  logic [SW-1:0] stat_in,
    output logic [SW-1:0] stat_out
);

    logic neg, ovf, sgn, zer;

    always_comb begin
        neg = value[W-1];
        ovf = neg ^ carry;
        sgn = neg ^ ovf;
        zer = ~|value;

        stat_out        = stat_in;
        stat_out[FLG_C] = carry;
        stat_out[FLG_Z] = zer;
        stat_out[FLG_N] = neg;
        stat_out[FLG_V] = ovf;
        stat_out[FLG_S] = sgn;
    end

endmodule

// File: rtl/bitops_bitfield.sv
module bitops_bitfield
    import bitops_pkg::*;
#(
    parameter int W     = WORD_W,
    localparam int IW   = $clog2(W),
    localparam int HALF = W / 2
) (
    input  logic [W-1:0]  din,
    input  logic [IW-1:0] sel,
    input  logic          t_in,
    output logic [W-1:0]  swapped,
    output logic [W-1:0]  inserted,
    output logic          picked
);

    for (genvar g = 0; g < HALF; g++) begin : g_swap
        assign swapped[g]        = din[g + HALF];
        assign swapped[g + HALF] = din[g];
    end

    for (genvar g = 0; g < W; g++) begin : g_insert
        assign inserted[g] = (sel == IW'(g)) ? t_in : din[g];
    end

    assign picked = din[sel];

endmodule

// File: rtl/bitops_status.sv
module bitops_status
    import bitops_pkg::*;
#(
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
    import bitops_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int SREG_W = STAT_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [OP_W-1:0]           op_sel,
    input  logic [DATA_W-1:0]         operand,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic [$clog2(SREG_W)-1:0] flag_idx,
    output logic [DATA_W-1:0]         result,
    output logic                      result_we,
    output logic [SREG_W-1:0]         sreg_next,
    output logic [SREG_W-1:0]         sreg
);

    localparam int FIW = $clog2(SREG_W);

    bop_ctrl_t          ctrl;
    logic [DATA_W-1:0]  sh_val, sw_val, ins_val;
    logic               sh_c, bit_pick;
    logic [SREG_W-1:0]  arith_stat, force_mask;

    assign ctrl = decode_op(op_sel);

    bitops_shifter #(.W(DATA_W)) u_shift (
        .op_code (op_sel),
        .din     (operand),
        .cin     (sreg[FLG_C]),
        .dout    (sh_val),
        .cout    (sh_c)
    );

    bitops_flagcalc #(.W(DATA_W), .SW(SREG_W)) u_flags (
        .value    (sh_val),
        .carry    (sh_c),
        .stat_in  (sreg),
        .stat_out (arith_stat)
    );

    bitops_bitfield #(.W(DATA_W)) u_bits (
        .din      (operand),
        .sel      (bit_idx),
        .t_in     (sreg[FLG_T]),
        .swapped  (sw_val),
        .inserted (ins_val),
        .picked   (bit_pick)
    );

    assign force_mask = SREG_W'(1) << flag_idx;

    always_comb begin
        case (ctrl.res_src)
            SRC_SHIFT:  result = sh_val;
            SRC_SWAP:   result = sw_val;
            SRC_INSERT: result = ins_val;
            default:    result = operand;
        endcase
        result_we = ctrl.wr_result;
    end

    always_comb begin
        sreg_next = sreg;
        case (ctrl.stat_src)
            ST_ARITH: sreg_next = arith_stat;
            ST_TCOPY: sreg_next[FLG_T] = bit_pick;
            ST_FORCE: sreg_next = ctrl.force_val ? (sreg | force_mask)
                                                 : (sreg & ~force_mask);
            default:  ;
        endcase
    end

    bitops_status #(.SW(SREG_W)) u_stat (
        .clk (clk),
        .rst (rst),
        .d   (sreg_next),
        .q   (sreg)
    );

    logic unused_fiw;
    assign unused_fiw = (FIW > 0) ? 1'b0 : 1'b1;

endmodule

// File: rtl/bitops_unit_chk.sv
module bitops_unit_chk
    import bitops_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int SREG_W = STAT_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic [OP_W-1:0]           op_sel,
    input logic [DATA_W-1:0]         operand,
    input logic [$clog2(DATA_W)-1:0] bit_idx,
    input logic [$clog2(SREG_W)-1:0] flag_idx,
    input logic [DATA_W-1:0]         result,
    input logic                      result_we,
    input logic [SREG_W-1:0]         sreg_next,
    input logic [SREG_W-1:0]         sreg
);

    localparam int HALF = DATA_W / 2;

    logic [SREG_W-1:0] fmask;
    logic [SREG_W-1:0] tmask;
    assign fmask = SREG_W'(1) << flag_idx;
    assign tmask = SREG_W'(1) << FLG_T;

    assert_rst_clear_R1: assert property (@(posedge clk)
        rst |=> (sreg == '0));

    assert_commit_R13: assert property (@(posedge clk)
        !rst |=> (sreg == $past(sreg_next)));

    assert_shl_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SHL) |-> (result[0] == 1'b0 && sreg_next[FLG_C] == operand[DATA_W-1]));

    assert_shr_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SHR) |-> (result[DATA_W-1] == 1'b0 && sreg_next[FLG_C] == operand[0]));

    assert_rcl_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_RCL) |-> (result[0] == sreg[FLG_C] && sreg_next[FLG_C] == operand[DATA_W-1]));

    assert_rcr_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_RCR) |-> (result[DATA_W-1] == sreg[FLG_C] && sreg_next[FLG_C] == operand[0]));

    assert_sar_sign_R6: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SAR) |-> (result[DATA_W-1] == operand[DATA_W-1] && sreg_next[FLG_C] == operand[0]));

    assert_shift_flags_R7: assert property (@(posedge clk) disable iff (rst)
        is_shift_op(op_sel) |->
            (result_we
             && sreg_next[FLG_N] == result[DATA_W-1]
             && sreg_next[FLG_Z] == (result == '0)
             && sreg_next[FLG_V] == (sreg_next[FLG_N] ^ sreg_next[FLG_C])
             && sreg_next[FLG_S] == (sreg_next[FLG_N] ^ sreg_next[FLG_V])
             && sreg_next[FLG_I] == sreg[FLG_I]
             && sreg_next[FLG_T] == sreg[FLG_T]
             && sreg_next[FLG_H] == sreg[FLG_H]));

    assert_nswap_R8: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_NSWP) |->
            (result_we && sreg_next == sreg
             && result[DATA_W-1:HALF] == operand[HALF-1:0]
             && result[HALF-1:0] == operand[DATA_W-1:HALF]));

    assert_tstore_R9: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_TSTO) |->
            (!result_we && sreg_next[FLG_T] == operand[bit_idx]
             && (sreg_next & ~tmask) == (sreg & ~tmask)));

    assert_tload_R10: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_TLOD) |->
            (result_we && result[bit_idx] == sreg[FLG_T] && sreg_next == sreg));

    assert_force_R11: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_FSET || op_sel == OP_FCLR) |->
            (!result_we
             && sreg_next[flag_idx] == (op_sel == OP_FSET)
             && (sreg_next & ~fmask) == (sreg & ~fmask)));

    assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_NOP || op_sel > OP_FCLR) |-> (!result_we && sreg_next == sreg));

endmodule

bind bitops_unit bitops_unit_chk #(.DATA_W(DATA_W), .SREG_W(SREG_W)) u_chk (.*);

// File: tb/bitops_unit_tb.sv
module bitops_unit_tb;

    localparam int NVEC = 20;
    localparam int WD_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_sel;
    logic [7:0] operand;
    logic [2:0] bit_idx;
    logic [2:0] flag_idx;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] sreg_next;
    logic [7:0] sreg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bitops_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .op_sel    (op_sel),
        .operand   (operand),
        .bit_idx   (bit_idx),
        .flag_idx  (flag_idx),
        .result    (result),
        .result_we (result_we),
        .sreg_next (sreg_next),
        .sreg      (sreg)
    );

    // {op, operand, bit_idx, flag_idx, starting status}
    localparam logic [25:0] VEC [NVEC] = '{
        {4'd1,  8'h81, 3'd0, 3'd0, 8'h00},
        {4'd1,  8'h80, 3'd0, 3'd0, 8'hE0},
        {4'd2,  8'h01, 3'd0, 3'd0, 8'h00},
        {4'd2,  8'hFE, 3'd0, 3'd0, 8'hFF},
        {4'd3,  8'h80, 3'd0, 3'd0, 8'h01},
        {4'd3,  8'h7F, 3'd0, 3'd0, 8'h00},
        {4'd4,  8'h01, 3'd0, 3'd0, 8'h00},
        {4'd4,  8'h00, 3'd0, 3'd0, 8'h01},
        {4'd5,  8'h80, 3'd0, 3'd0, 8'h00},
        {4'd5,  8'h81, 3'd0, 3'd0, 8'hA0},
        {4'd6,  8'hA5, 3'd0, 3'd0, 8'h5A},
        {4'd6,  8'h0F, 3'd0, 3'd0, 8'h00},
        {4'd7,  8'h10, 3'd4, 3'd0, 8'h00},
        {4'd7,  8'hEF, 3'd4, 3'd0, 8'hFF},
        {4'd8,  8'h00, 3'd7, 3'd0, 8'h40},
        {4'd8,  8'hFF, 3'd0, 3'd0, 8'hBF},
        {4'd9,  8'h00, 3'd0, 3'd5, 8'h00},
        {4'd10, 8'h00, 3'd0, 3'd7, 8'hFF},
        {4'd0,  8'h55, 3'd0, 3'd0, 8'h3C},
        {4'd15, 8'hAA, 3'd0, 3'd0, 8'hC3}
    };

    // expected {write strobe, result, next status} from the requirements
    function automatic logic [16:0] expect_of(input logic [3:0] op, input logic [7:0] a,
                                              input logic [2:0] bi, input logic [2:0] fi,
                                              input logic [7:0] s);
        logic [7:0] r, ns;
        logic       we, c, sh;
        r = a; ns = s; we = 1'b0; c = s[0]; sh = 1'b0;
        case (op)
            4'd1: begin r = {a[6:0], 1'b0}; c = a[7]; sh = 1'b1; end
            4'd2: begin r = {1'b0, a[7:1]}; c = a[0]; sh = 1'b1; end
            4'd3: begin r = {a[6:0], s[0]}; c = a[7]; sh = 1'b1; end
            4'd4: begin r = {s[0], a[7:1]}; c = a[0]; sh = 1'b1; end
            4'd5: begin r = {a[7], a[7:1]}; c = a[0]; sh = 1'b1; end
            4'd6: begin r = {a[3:0], a[7:4]}; we = 1'b1; end
            4'd7: ns[6] = a[bi];
            4'd8: begin r[bi] = s[6]; we = 1'b1; end
            4'd9: ns[fi] = 1'b1;
            4'd10: ns[fi] = 1'b0;
            default: ;
        endcase
        if (sh) begin
            we    = 1'b1;
            ns[0] = c;
            ns[1] = (r == 8'h00);
            ns[2] = r[7];
            ns[3] = r[7] ^ c;
            ns[4] = r[7] ^ (r[7] ^ c);
        end
        return {we, r, ns};
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R8";
            4'd7: return "R9";
            4'd8: return "R10";
            4'd9, 4'd10: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a,
                         input logic [2:0] bi, input logic [2:0] fi);
        @(negedge clk);
        op_sel = op; operand = a; bit_idx = bi; flag_idx = fi;
        #1;
    endtask

    // build a status word using only set/clear flag operations (R11 path)
    task automatic load_status(input logic [7:0] s);
        for (int i = 0; i < 8; i++) begin
            drive(s[i] ? 4'd9 : 4'd10, 8'h00, 3'd0, 3'(i));
        end
    endtask

    initial begin
        #(WD_CYCLES * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [16:0] e;
        rst = 1'b1; op_sel = 4'd0; operand = 8'h00; bit_idx = 3'd0; flag_idx = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        check(sreg == 8'h00, "R1", "status after reset", 32'(sreg), 32'h0);
        check(result_we == 1'b0, "R12", "strobe idle in reset", 32'(result_we), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            logic [3:0] vop;
            logic [7:0] va, vs;
            logic [2:0] vb, vf;
            string      rq;
            {vop, va, vb, vf, vs} = VEC[k];
            rq = req_of(vop);
            e  = expect_of(vop, va, vb, vf, vs);
            load_status(vs);
            drive(vop, va, vb, vf);
            check(sreg == vs, "R11", "status built from flag ops", 32'(sreg), 32'(vs));
            check(result_we == e[16], rq, "write strobe", 32'(result_we), 32'(e[16]));
            if (e[16])
                check(result == e[15:8], rq, "result", 32'(result), 32'(e[15:8]));
            check(sreg_next == e[7:0], (vop >= 4'd1 && vop <= 4'd5) ? "R7" : rq,
                  "next status", 32'(sreg_next), 32'(e[7:0]));
            @(posedge clk);
            #1;
            check(sreg == e[7:0], "R13", "status one edge later", 32'(sreg), 32'(e[7:0]));
        end

        // R13: status holds until the edge while sreg_next already shows the update
        load_status(8'h00);
        drive(4'd9, 8'h00, 3'd0, 3'd3);
        check(sreg == 8'h00, "R13", "status before edge", 32'(sreg), 32'h00);
        check(sreg_next == 8'h08, "R13", "next status same cycle", 32'(sreg_next), 32'h08);

        // R4/R5: carry chain across back-to-back rotates
        load_status(8'h00);
        drive(4'd3, 8'h80, 3'd0, 3'd0);
        check(result == 8'h00 && sreg_next[0], "R4", "rotate left out", 32'({sreg_next[0], result}), 32'h100);
        drive(4'd3, 8'h00, 3'd0, 3'd0);
        check(result == 8'h01, "R4", "carry enters bit 0", 32'(result), 32'h01);
        drive(4'd4, 8'h00, 3'd0, 3'd0);
        check(result == 8'h00 && !sreg_next[0], "R5", "rotate right with clear carry",
              32'({sreg_next[0], result}), 32'h000);

        // R9/R10: every bit index copied through T and back
        for (int b = 0; b < 8; b++) begin
            load_status(8'h00);
            drive(4'd7, 8'(1 << b), 3'(b), 3'd0);
            check(sreg_next == 8'h40, "R9", "bit to T", 32'(sreg_next), 32'h40);
            drive(4'd8, 8'h00, 3'(b), 3'd0);
            check(result == 8'(1 << b), "R10", "T to bit", 32'(result), 32'(8'(1 << b)));
        end

        // R1: reset takes priority over a flag operation in the same cycle
        load_status(8'hFF);
        @(negedge clk);
        rst = 1'b1; op_sel = 4'd9; flag_idx = 3'd0;
        @(posedge clk);
        #1;
        check(sreg == 8'h00, "R1", "reset wins over flag set", 32'(sreg), 32'h00);
        @(negedge clk);
        rst = 1'b0; op_sel = 4'd0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule